// File: doc/BRIEF.md
# Memory Hotplug Slot Register Bank

This block keeps a presence bitmap for up to 256 hot-pluggable memory slots and shows it to firmware through a byte-wide I/O port. Platform logic raises an add or a remove request with a slot index. Each request updates the slot's presence bit and latches one shared hotplug event flag. That flag, gated by a firmware-controlled enable byte, drives a level-sensitive system interrupt.

Firmware reads the bitmap through a read-only presence window. It acknowledges a completed removal by writing into a separate, write-only eject window. Each set bit of such a write becomes a one-cycle pulse on that slot's line of a wide eject vector. Platform logic then releases the slot's memory. One external hotplug source is folded into the same status byte and into the same interrupt.

Top module: `mhp_slot_bank`

## Requirements
- R1: After reset, every presence byte reads 0, the status byte event bit (bit 3) is 0, no eject pulse is driven, and the interrupt is low unless the external source is enabled and active.
- R2: Slot n is held in bit n mod 8 of the presence byte at offset 0x20 + n/8. A read of that offset returns the stored byte in the same cycle that the read strobe and address are applied.
- R3: An add request sets the slot's presence bit and the event bit, both visible from the next clock edge.
- R4: A remove request clears the slot's presence bit and sets the event bit from the next clock edge. Add and remove requests for two different slots in the same cycle both take effect.
- R5: An add and a remove request for the same slot in the same cycle leave the slot absent, and they set the event bit.
- R6: A write of byte D to the eject window at offset 0x40 + k drives eject_pulse[8k+b] high for exactly one cycle, in the cycle after the write, for each set bit b of D. The write acts whether or not the slot is present. Clear bits, and cycles without an eject write, produce no pulse.
- R7: Writes to the presence window leave the bitmap unchanged. Eject writes do not change presence. Reads of the eject window return 0.
- R8: A write to the status byte at offset 0x00 with bit 3 set clears the event bit. A write with bit 3 clear leaves it unchanged.
- R9: An add or remove request in the same cycle as a clearing write keeps the event bit set.
- R10: The status byte reads the event flag at bit 3 and the external source at bit 1, with all other bits 0. The interrupt is high exactly when (event AND enable bit 3) OR (external AND enable bit 1). All other enable bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_addr | input | 8 | Byte offset within the block's I/O region |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, zero when io_rd is low |
| add_req | input | 1 | Slot insertion request |
| add_slot | input | 8 | Slot index for add_req |
| rem_req | input | 1 | Slot removal request |
| rem_slot | input | 8 | Slot index for rem_req |
| ext_hp_sts | input | 1 | Status of the external hotplug source |
| gpe_en | input | 8 | Event enable byte |
| eject_pulse | output | 256 | One-cycle eject pulse for each slot |
| sci_level | output | 1 | Level-sensitive system interrupt |

## Verification
Two pairs of functions can land in one cycle. An add and a remove can name the same slot, and a request can arrive in the same cycle as a host write that clears the event flag. The bench drives both pairs on the same negative edge, then reads the presence byte and the status byte back. It judges the result against a behavioural model that applies the priority rules: remove over add, and a request over the clear. Eject pulses and the interrupt level are compared with the model on every cycle.

// File: rtl/mhp_pkg.sv
package mhp_pkg;
  localparam int EVT_BIT = 3;
  localparam int EXT_BIT = 1;

  // byte offset of a slot inside its window
  function automatic int slot_byte(input int slot);
    return slot / 8;
  endfunction

  // bit position of a slot inside its byte
  function automatic int slot_bit(input int slot);
    return slot % 8;
  endfunction

  // status byte layout
  function automatic logic [7:0] pack_status(input logic evt, input logic ext);
    logic [7:0] s;
    s = 8'h00;
    s[EVT_BIT] = evt;
    s[EXT_BIT] = ext;
    return s;
  endfunction

  // interrupt level from status and enable
  function automatic logic irq_level(input logic [7:0] sts, input logic [7:0] en);
    logic [7:0] m;
    m = 8'h00;
    m[EVT_BIT] = 1'b1;
    m[EXT_BIT] = 1'b1;
    return |(sts & en & m);
  endfunction
endpackage

// File: rtl/mhp_presence.sv
module mhp_presence #(
  parameter int SLOTS = 256,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_req,
  input  logic [IDX_W-1:0] add_slot,
  input  logic             rem_req,
  input  logic [IDX_W-1:0] rem_slot,
  output logic [SLOTS-1:0] pres_map
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit_add, hit_rem;
    assign hit_add = add_req && (add_slot == IDX_W'(g));
    assign hit_rem = rem_req && (rem_slot == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pres_map[g] <= 1'b0;
      else if (hit_rem) pres_map[g] <= 1'b0;
      else if (hit_add) pres_map[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/mhp_eject.sv
module mhp_eject #(
  parameter int SLOTS   = 256,
  parameter int AW      = 8,
  parameter int EJ_BASE = 'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [AW-1:0]    io_addr,
  input  logic [7:0]       io_wdata,
  output logic [SLOTS-1:0] eject_pulse
);
  localparam int BYTES = SLOTS / 8;

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    logic hit;
    assign hit = io_wr && (io_addr == AW'(EJ_BASE + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eject_pulse[8*k +: 8] <= 8'h00;
      else        eject_pulse[8*k +: 8] <= hit ? io_wdata : 8'h00;
    end
  end
endmodule

// File: rtl/mhp_gpe.sv
module mhp_gpe
  import mhp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_set,
  input  logic       evt_clr,
  input  logic       ext_hp_sts,
  input  logic [7:0] gpe_en,
  output logic       evt_q,
  output logic [7:0] sts_byte,
  output logic       sci_level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_q <= 1'b0;
    else if (evt_set) evt_q <= 1'b1;
    else if (evt_clr) evt_q <= 1'b0;
  end

  assign sts_byte  = pack_status(evt_q, ext_hp_sts);
  assign sci_level = irq_level(sts_byte, gpe_en);
endmodule

// File: rtl/mhp_slot_bank.sv
module mhp_slot_bank
  import mhp_pkg::*;
#(
  parameter int SLOTS     = 256,
  parameter int IDX_W     = $clog2(SLOTS),
  parameter int AW        = 8,
  parameter int STS_OFS   = 'h00,
  parameter int PRES_BASE = 'h20,
  parameter int EJ_BASE   = 'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [AW-1:0]    io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic             add_req,
  input  logic [IDX_W-1:0] add_slot,
  input  logic             rem_req,
  input  logic [IDX_W-1:0] rem_slot,
  input  logic             ext_hp_sts,
  input  logic [7:0]       gpe_en,
  output logic [SLOTS-1:0] eject_pulse,
  output logic             sci_level
);
  localparam int BYTES = SLOTS / 8;

  // named internal events, observed by the checker
  logic [SLOTS-1:0] pres_map;
  logic             evt_q;
  logic             evt_set;
  logic             evt_clr;
  logic [7:0]       sts_byte;
  logic [7:0]       rd_val;

  assign evt_set = add_req || rem_req;
  assign evt_clr = io_wr && (io_addr == AW'(STS_OFS)) && io_wdata[EVT_BIT];

  mhp_presence #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_pres (
    .clk(clk), .rst_n(rst_n),
    .add_req(add_req), .add_slot(add_slot),
    .rem_req(rem_req), .rem_slot(rem_slot),
    .pres_map(pres_map)
  );

  mhp_eject #(.SLOTS(SLOTS), .AW(AW), .EJ_BASE(EJ_BASE)) u_ej (
    .clk(clk), .rst_n(rst_n),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .eject_pulse(eject_pulse)
  );

  mhp_gpe u_gpe (
    .clk(clk), .rst_n(rst_n),
    .evt_set(evt_set), .evt_clr(evt_clr),
    .ext_hp_sts(ext_hp_sts), .gpe_en(gpe_en),
    .evt_q(evt_q), .sts_byte(sts_byte), .sci_level(sci_level)
  );

  // read decode: status byte, presence window; everything else reads zero
  always_comb begin
    rd_val = 8'h00;
    if (io_addr == AW'(STS_OFS)) rd_val = sts_byte;
    for (int k = 0; k < BYTES; k++) begin
      if (io_addr == AW'(PRES_BASE + k)) rd_val = pres_map[8*k +: 8];
    end
  end

  assign io_rdata = io_rd ? rd_val : 8'h00;
endmodule

// File: rtl/mhp_slot_bank_chk.sv
module mhp_slot_bank_chk
  import mhp_pkg::*;
#(
  parameter int SLOTS   = 256,
  parameter int IDX_W   = $clog2(SLOTS),
  parameter int AW      = 8,
  parameter int STS_OFS = 'h00,
  parameter int EJ_BASE = 'h40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic [AW-1:0]    io_addr,
  input logic [7:0]       io_wdata,
  input logic             add_req,
  input logic [IDX_W-1:0] add_slot,
  input logic             rem_req,
  input logic [IDX_W-1:0] rem_slot,
  input logic             ext_hp_sts,
  input logic [7:0]       gpe_en,
  input logic [SLOTS-1:0] eject_pulse,
  input logic             sci_level,
  input logic [SLOTS-1:0] pres_map,
  input logic             evt_q
);
  logic ej_wr;
  assign ej_wr = io_wr && (io_addr >= AW'(EJ_BASE)) && (io_addr < AW'(EJ_BASE + SLOTS/8));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pres_map == '0 && !evt_q && eject_pulse == '0));

  assert_add_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_req && !(rem_req && rem_slot == add_slot)) |=> pres_map[$past(add_slot)]);

  assert_rem_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_req |=> !pres_map[$past(rem_slot)]);

  assert_no_stray_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ej_wr |=> (eject_pulse == '0));

  assert_first_byte_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(EJ_BASE)) |=> (eject_pulse[7:0] == $past(io_wdata)));

  assert_map_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_req || rem_req) |=> $stable(pres_map));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(STS_OFS) && io_wdata[EVT_BIT] && !add_req && !rem_req) |=> !evt_q);

  assert_request_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (add_req || rem_req) |=> evt_q);

  always_comb begin
    if (rst_n) begin
      assert_irq_R10: assert (sci_level ==
        ((evt_q && gpe_en[EVT_BIT]) || (ext_hp_sts && gpe_en[EXT_BIT])));
    end
  end
endmodule

bind mhp_slot_bank mhp_slot_bank_chk #(
  .SLOTS(SLOTS), .IDX_W(IDX_W), .AW(AW), .STS_OFS(STS_OFS), .EJ_BASE(EJ_BASE)
) u_chk (.*);

// File: tb/sim_mhp_slot_bank.sv
module sim_mhp_slot_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic add_req = 1'b0, rem_req = 1'b0;
  logic [7:0] add_slot = 8'h00, rem_slot = 8'h00;
  logic ext_hp_sts = 1'b0;
  logic [7:0] gpe_en = 8'h00;
  logic [255:0] eject_pulse;
  logic sci_level;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mhp_slot_bank u0 (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .add_req(add_req), .add_slot(add_slot), .rem_req(rem_req), .rem_slot(rem_slot),
    .ext_hp_sts(ext_hp_sts), .gpe_en(gpe_en),
    .eject_pulse(eject_pulse), .sci_level(sci_level)
  );

  // behavioural reference model
  bit m_pres[256];
  bit m_evt;
  logic [255:0] m_ej;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pres[i]) m_pres[i] = 1'b0;
      m_evt = 1'b0;
      m_ej = '0;
    end else begin
      if (add_req) m_pres[add_slot] = 1'b1;
      if (rem_req) m_pres[rem_slot] = 1'b0;
      if (add_req || rem_req) m_evt = 1'b1;
      else if (io_wr && io_addr == 8'h00 && io_wdata[3]) m_evt = 1'b0;
      m_ej = '0;
      if (io_wr && io_addr >= 8'h40 && io_addr <= 8'h5F)
        for (int b = 0; b < 8; b++) m_ej[(io_addr - 8'h40) * 8 + b] = io_wdata[b];
    end
  end

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 8'h00) begin
      v[3] = m_evt;
      v[1] = ext_hp_sts;
    end else if (a >= 8'h20 && a <= 8'h3F) begin
      for (int b = 0; b < 8; b++) v[b] = m_pres[(a - 8'h20) * 8 + b];
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(eject_pulse === m_ej, "R6 eject pulses", eject_pulse, m_ej);
      check(sci_level === ((m_evt && gpe_en[3]) || (ext_hp_sts && gpe_en[1])),
            "R10 interrupt level", 256'(sci_level),
            256'((m_evt && gpe_en[3]) || (ext_hp_sts && gpe_en[1])));
    end
  end

  task automatic rd_chk(input logic [7:0] a, input string tag);
    @(negedge clk); #1;
    io_rd = 1'b1; io_addr = a; #1;
    check(io_rdata === exp_read(a), tag, 256'(io_rdata), 256'(exp_read(a)));
    io_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic req(input bit a, input logic [7:0] as, input bit r, input logic [7:0] rs);
    @(negedge clk); #1;
    add_req = a; add_slot = as; rem_req = r; rem_slot = rs;
    @(negedge clk); #1;
    add_req = 1'b0; rem_req = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    for (int k = 0; k < 32; k++) rd_chk(8'h20 + 8'(k), "R1 presence after reset");
    rd_chk(8'h00, "R1 status after reset");
    check(sci_level === 1'b0, "R1 interrupt after reset", 256'(sci_level), 256'h0);

    // R3 / R2: adds and bit mapping
    gpe_en = 8'h08;
    req(1, 8'd0, 0, 8'd0);
    req(1, 8'd9, 0, 8'd0);
    req(1, 8'd255, 0, 8'd0);
    rd_chk(8'h20, "R2 R3 slot 0 byte");
    rd_chk(8'h21, "R2 R3 slot 9 byte");
    rd_chk(8'h3F, "R2 R3 slot 255 byte");
    rd_chk(8'h00, "R3 event set");

    // R8: clear rules
    wr(8'h00, 8'hF7);
    rd_chk(8'h00, "R8 write without bit3 keeps event");
    wr(8'h00, 8'h08);
    rd_chk(8'h00, "R8 write-one clears event");

    // R7: ignored accesses
    wr(8'h21, 8'hFF);
    rd_chk(8'h21, "R7 presence write ignored");
    rd_chk(8'h41, "R7 eject window reads zero");

    // R4: remove, plus two different slots at once
    req(0, 8'd0, 1, 8'd9);
    rd_chk(8'h21, "R4 slot 9 removed");
    req(1, 8'd3, 1, 8'd200);
    rd_chk(8'h20, "R4 simultaneous add slot 3");
    rd_chk(8'h39, "R4 simultaneous remove slot 200");

    // R5: same slot add and remove
    req(1, 8'd100, 0, 8'd0);
    wr(8'h00, 8'h08);
    req(1, 8'd100, 1, 8'd100);
    rd_chk(8'h2C, "R5 remove wins same slot");
    rd_chk(8'h00, "R5 event set");

    // R9: request beats clear in the same cycle
    wr(8'h00, 8'h08);
    @(negedge clk); #1;
    io_wr = 1'b1; io_addr = 8'h00; io_wdata = 8'h08;
    add_req = 1'b1; add_slot = 8'd17;
    @(negedge clk); #1;
    io_wr = 1'b0; add_req = 1'b0;
    rd_chk(8'h00, "R9 event kept over clear");
    rd_chk(8'h22, "R9 add applied");

    // R6: eject writes, present and absent slots, multi-bit, zero
    wr(8'h43, 8'hA5);
    wr(8'h40, 8'h01);
    wr(8'h5F, 8'hFF);
    wr(8'h44, 8'h00);
    rd_chk(8'h20, "R7 eject leaves presence");
    rd_chk(8'h3F, "R7 eject leaves presence top");

    // R10: enable gating and external source
    gpe_en = 8'hF5; ext_hp_sts = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk(8'h00, "R10 status shows external");
    gpe_en = 8'h02;
    repeat (2) @(negedge clk);
    ext_hp_sts = 1'b0; gpe_en = 8'h08;
    wr(8'h00, 8'h08);
    repeat (2) @(negedge clk);
    check(sci_level === 1'b0, "R10 interrupt low after clear", 256'(sci_level), 256'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule